// File: doc/BRIEF.md
# Register-Mapped Byte UART

A UART with one transmit path and one receive path, reached through a small window of 32-bit registers. A host write to the transmit data word takes the low byte of the written word and sends it on the serial output line. The frame is one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. The bit period is fixed when the block is built, from a tick divider and a 16x oversampling factor.

The receiver samples the input line at 16 times the bit rate and takes each bit at its centre. It places a completed byte in a single holding register and raises a receive-ready flag. While that flag is set, the holding register keeps its byte. Any byte that completes in that time is dropped, and a sticky overrun output records the drop. A host read of the receive data word returns the held byte and lowers the flag in the same access. The status word shows both flags. Reads of the status word change nothing. The block has no FIFO, no interrupt output and no baud setting that can be changed at run time.

Top module: `byte_uart`

## Requirements
- R1: After reset, the status word reads 0x2: bit 1, transmit-ready, is 1 and bit 0, receive-ready, is 0. The receive and transmit data words read 0. The serial output is high and the overrun output is 0.
- R2: The register index is the byte address shifted right by two, and address bits 1:0 are ignored. Index 0 (byte 0x00) is transmit data, index 1 (0x04) is receive data and index 5 (0x14) is status.
- R3: An accepted write to index 0 sends wdata bits 7:0 as one 8N1 frame, least significant bit first. Each bit lasts TICK_DIV*OVS clocks, starting at the clock edge that accepts the write. The line idles high.
- R4: Transmit-ready (status bit 1) is low from the edge that accepts a write until exactly 10 bit periods later, and it is high again from that edge on.
- R5: A write to index 0 while transmit-ready is low is discarded, and the frame in progress is unchanged.
- R6: A correctly framed byte on the serial input sets receive-ready (status bit 0). A read of index 1 then returns the byte in bits 7:0, with bits 31:8 at zero.
- R7: A read of index 1 clears receive-ready in that same access. The byte stays in the holding register and later reads of index 1 still return it.
- R8: A read of the status word has no side effect, so two reads in a row return the same value.
- R9: While receive-ready is set, a newly completed byte does not overwrite the holding register. That byte is dropped and the overrun output goes high and stays high. After the held byte is read, the next byte is accepted.
- R10: Writes to the status word are ignored. Reads of indices 2, 3, 4, 6 and 7 return 0, and writes to those indices change no register and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of a read strobe |
| tx_o | output | 1 | Serial output |
| rx_i | input | 1 | Serial input |
| overrun_o | output | 1 | Sticky flag: a received byte was dropped |

## Verification
The transmitter is tried with all 256 byte values. The upper bits of each written word are filled with copies of the byte, so a frame that carried any bit beyond bit 7 would show up. In every frame a second, conflicting write is issued while the line is busy, which separates a design that discards writes while busy from one that reloads. Transmit-ready is read just before and just after the tenth bit boundary, which catches a busy window that is one bit too short or too long. The receiver is fed all 256 values as serial frames. A read sequence of status, data, status and data again separates read-to-clear from a read of status that clears, and from a data read that does not clear. Two back-to-back frames with no read between them distinguish refusal from overwrite. Writes to the status word and to each unmapped index, followed by readback and a watch on the serial line, show that these writes have no effect.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned IDX_TXD    = 0;
  localparam int unsigned IDX_RXD    = 1;
  localparam int unsigned IDX_STAT   = 5;
  localparam int unsigned ST_RX_RDY  = 0;
  localparam int unsigned ST_TX_RDY  = 1;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_baud_tick.sv
module uart_baud_tick #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every_clk
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                        pre_q <= '0;
        else if (pre_q == PW'(TICK_DIV-1))  pre_q <= '0;
        else                                pre_q <= pre_q + 1'b1;
      end
      assign tick_o = (pre_q == PW'(TICK_DIV-1));
    end
  endgenerate
endmodule

// File: rtl/uart_tx_ser.sv
module uart_tx_ser
  import uart_pkg::*;
#(
  parameter int unsigned BIT_CLKS = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam int unsigned BW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] sh_q;
  logic [CW-1:0]         cnt_q;
  logic [BW-1:0]         left_q;
  logic                  busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (!busy_q) begin
      if (load_i) begin
        busy_q <= 1'b1;
        sh_q   <= {1'b1, data_i, 1'b0};
        cnt_q  <= CW'(BIT_CLKS-1);
        left_q <= BW'(FRAME_BITS-1);
      end
    end else if (cnt_q == '0) begin
      if (left_q == '0) begin
        busy_q <= 1'b0;
      end else begin
        sh_q   <= {1'b1, sh_q[FRAME_BITS-1:1]};
        left_q <= left_q - 1'b1;
        cnt_q  <= CW'(BIT_CLKS-1);
      end
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              valid_o,
  output logic [BYTE_W-1:0] data_o
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = OVS/2 - 1;

  logic [1:0]        sync_q;
  logic              rxs;
  rx_state_e         st_q;
  logic [CW-1:0]     cnt_q;
  logic [2:0]        bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end
  assign rxs = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RX_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      sh_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (tick_i) begin
        unique case (st_q)
          RX_IDLE: begin
            if (!rxs) begin
              st_q  <= RX_START;
              cnt_q <= '0;
            end
          end
          RX_START: begin
            if (cnt_q == CW'(MID)) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= rxs ? RX_IDLE : RX_DATA;  // glitch rejection at mid-bit
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == CW'(OVS-1)) begin
              cnt_q <= '0;
              sh_q  <= {rxs, sh_q[BYTE_W-1:1]};
              if (bit_q == 3'd7) st_q <= RX_STOP;
              bit_q <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == CW'(OVS-1)) begin
              cnt_q <= '0;
              vld_q <= rxs;  // bad stop bit: frame dropped
              st_q  <= RX_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: st_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign valid_o = vld_q;
  assign data_o  = sh_q;
endmodule

// File: rtl/uart_regs.sv
module uart_regs
  import uart_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic              tx_load_o,
  output logic [BYTE_W-1:0] tx_data_o,
  input  logic              tx_busy_i,
  input  logic              rx_valid_i,
  input  logic [BYTE_W-1:0] rx_data_i,
  output logic              rx_rdy_o,
  output logic [BYTE_W-1:0] rx_hold_o,
  output logic              overrun_o
);
  localparam int unsigned IW = ADDR_W - 2;

  logic [IW-1:0]     idx;
  logic              rd_rx;
  logic              rx_rdy_q;
  logic [BYTE_W-1:0] hold_q;
  logic              ovr_q;
  logic              unused_bits;

  assign idx         = addr_i[ADDR_W-1:2];
  assign unused_bits = ^{addr_i[1:0], wdata_i[REG_W-1:BYTE_W]};
  assign rd_rx       = req_i && !we_i && (idx == IW'(IDX_RXD));

  assign tx_load_o = req_i && we_i && (idx == IW'(IDX_TXD)) && !tx_busy_i;
  assign tx_data_o = wdata_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rdy_q <= 1'b0;
      hold_q   <= '0;
      ovr_q    <= 1'b0;
    end else begin
      if (rx_valid_i) begin
        if (!rx_rdy_q) begin
          hold_q   <= rx_data_i;
          rx_rdy_q <= 1'b1;
        end else begin
          ovr_q <= 1'b1;
        end
      end
      if (rd_rx) rx_rdy_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (idx == IW'(IDX_RXD)) begin
        rdata_o[BYTE_W-1:0] = hold_q;
      end else if (idx == IW'(IDX_STAT)) begin
        rdata_o[ST_RX_RDY] = rx_rdy_q;
        rdata_o[ST_TX_RDY] = !tx_busy_i;
      end
    end
  end

  assign rx_rdy_o  = rx_rdy_q;
  assign rx_hold_o = hold_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/byte_uart.sv
module byte_uart
  import uart_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned TICK_DIV = 4,
  parameter int unsigned OVS      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              tx_o,
  input  logic              rx_i,
  output logic              overrun_o
);
  localparam int unsigned BIT_CLKS = TICK_DIV * OVS;

  logic              tick;
  logic              tx_load;
  logic [BYTE_W-1:0] tx_data;
  logic              tx_busy;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_data;
  logic              rx_rdy;
  logic [BYTE_W-1:0] rx_hold;

  uart_baud_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  uart_tx_ser #(.BIT_CLKS(BIT_CLKS)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(tx_load),
    .data_i(tx_data),
    .busy_o(tx_busy),
    .tx_o  (tx_o)
  );

  uart_rx_deser #(.OVS(OVS)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .rx_i   (rx_i),
    .valid_o(rx_valid),
    .data_o (rx_data)
  );

  uart_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .tx_load_o (tx_load),
    .tx_data_o (tx_data),
    .tx_busy_i (tx_busy),
    .rx_valid_i(rx_valid),
    .rx_data_i (rx_data),
    .rx_rdy_o  (rx_rdy),
    .rx_hold_o (rx_hold),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/byte_uart_chk.sv
module byte_uart_chk
  import uart_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic              tx_o,
  input logic              tx_busy,
  input logic              rx_rdy,
  input logic [7:0]        rx_hold,
  input logic              rx_valid,
  input logic              overrun_o
);
  localparam int unsigned IW = ADDR_W - 2;
  logic [IW-1:0] idx;
  logic          rd_rx, rd_st, wr_tx;
  assign idx   = addr_i[ADDR_W-1:2];
  assign rd_rx = req_i && !we_i && idx == IW'(IDX_RXD);
  assign rd_st = req_i && !we_i && idx == IW'(IDX_STAT);
  assign wr_tx = req_i && we_i && idx == IW'(IDX_TXD);

  p_idle_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy |-> tx_o);

  p_busy_from_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy) |-> $past(wr_tx));

  p_read_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rx |=> !rx_rdy);

  p_status_read_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_st && !rx_valid |=> $stable(rx_rdy));

  p_hold_kept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rdy && !rd_rx |=> rx_rdy && $stable(rx_hold));

  p_overrun_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_rdy && rx_valid));

  p_overrun_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !we_i && idx != IW'(IDX_RXD) && idx != IW'(IDX_STAT) |-> rdata_o == 32'h0);
endmodule

bind byte_uart byte_uart_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .tx_o     (tx_o),
  .tx_busy  (tx_busy),
  .rx_rdy   (rx_rdy),
  .rx_hold  (rx_hold),
  .rx_valid (rx_valid),
  .overrun_o(overrun_o)
);

// File: tb/byte_uart_bench.sv
`timescale 1ns/1ps
module byte_uart_bench;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BIT    = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0;
  logic              we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              tx;
  logic              rx = 1'b1;
  logic              ovr;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  byte_uart #(.ADDR_W(ADDR_W), .TICK_DIV(1), .OVS(16)) u_byte_uart (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .tx_o(tx), .rx_i(rx), .overrun_o(ovr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk); @(negedge clk);
    req = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b);
    logic [9:0] fr;
    fr = {1'b1, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rx = fr[k];
      repeat (BIT) @(negedge clk);
    end
    rx = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [9:0]  got;
    logic [7:0]  bb;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_rd(5'h14, d); check("R1 status", d, 32'h2);
    bus_rd(5'h04, d); check("R1 rx data", d, 32'h0);
    bus_rd(5'h00, d); check("R1 tx data read", d, 32'h0);
    check("R1 tx line", {31'b0, tx}, 32'h1);
    check("R1 overrun", {31'b0, ovr}, 32'h0);
    // R2 low address bits ignored
    bus_rd(5'h17, d); check("R2 status alias", d, 32'h2);

    // R3 R4 R5 transmit sweep
    for (int b = 0; b < 256; b++) begin
      bb = 8'(b);
      bus_wr(5'h00, {bb, bb, bb, bb});
      bus_rd(5'h14, d); check("R4 busy after write", d, 32'h0);
      bus_wr(5'h00, {24'hA5A5A5, ~bb});
      repeat (6) @(negedge clk);
      for (int k = 0; k < 10; k++) begin
        got[k] = tx;
        if (k < 9) repeat (BIT) @(negedge clk);
      end
      check("R3,R5 frame", {22'b0, got}, {22'b0, 1'b1, bb, 1'b0});
      repeat (7) @(negedge clk);
      bus_rd(5'h14, d); check("R4 busy last clock", d, 32'h0);
      bus_rd(5'h14, d); check("R4 ready after 10 bits", d, 32'h2);
    end

    // R6 R7 R8 receive sweep
    for (int b = 0; b < 256; b++) begin
      bb = 8'(b ^ 8'h5C);
      send_rx(bb);
      repeat (4) @(negedge clk);
      bus_rd(5'h14, d); check("R6 rx ready", d, 32'h3);
      bus_rd(5'h14, d); check("R8 status repeat", d, 32'h3);
      bus_rd(5'h04, d); check("R6 rx byte", d, {24'h0, bb});
      bus_rd(5'h14, d); check("R7 cleared", d, 32'h2);
      bus_rd(5'h04, d); check("R7 byte kept", d, {24'h0, bb});
    end
    check("R9 no overrun yet", {31'b0, ovr}, 32'h0);

    // R9 overrun
    send_rx(8'h3C);
    send_rx(8'hC3);
    repeat (4) @(negedge clk);
    check("R9 overrun set", {31'b0, ovr}, 32'h1);
    bus_rd(5'h04, d); check("R9 first byte kept", d, 32'h3C);
    send_rx(8'h81);
    repeat (4) @(negedge clk);
    bus_rd(5'h04, d); check("R9 next accepted", d, 32'h81);
    check("R9 overrun sticky", {31'b0, ovr}, 32'h1);

    // R10 ignored writes
    bus_wr(5'h14, 32'hFFFF_FFFF);
    bus_rd(5'h14, d); check("R10 status write ignored", d, 32'h2);
    for (int i = 2; i < 8; i++) begin
      if (i == 5) continue;
      bus_wr(5'(i * 4), 32'hFFFF_FF00 | 32'(i));
      bus_rd(5'(i * 4), d); check("R10 unmapped read", d, 32'h0);
      check("R10 no frame", {31'b0, tx}, 32'h1);
    end
    bus_rd(5'h14, d); check("R10 status intact", d, 32'h2);
    bus_rd(5'h04, d); check("R10 rx data intact", d, 32'h81);
    for (int k = 0; k < 2 * BIT; k++) begin
      if (tx !== 1'b1) check("R10 line stays idle", {31'b0, tx}, 32'h1);
      @(negedge clk);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule